// File: doc/BRIEF.md
# Sponge Operation Command Sequencer

This block is the control state machine of a hashing engine built on a 1600-bit sponge. It covers the fixed-length hash, the extendable-output function, its customisable variant and the keyed variant. Software drives it with single-cycle commands. Starting an operation opens the absorb phase. A process command closes that phase with the final permutation. After that, the squeeze phase exposes output state. A run command asks for one more permutation, which yields another block of output. A done command returns the engine to idle. The permutation itself is not part of this block. A request/acknowledge handshake stands in for it, and a stub answers that handshake after a fixed number of cycles.

The configuration register holds the strength, the function family and a keyed-enable bit. It can be written only while the engine is idle. At start, the block latches two values from it. The first is the rate in 32-bit words, which is the sponge width minus twice the strength, divided by 32. The second is the function kind. Both stay constant for the whole operation.

Three status bits report idle, absorb and squeeze. At most one of them is high. All three are low while a permutation is running. A command that the current phase does not accept sets a sticky error flag and is otherwise dropped.

Top module: `sponge_cmd_seq`

## Requirements
- R1: After reset, idle_o=1 and absorb_o, squeeze_o and err_o are 0. rate_words_o=0 and op_kind_o=0. The stored configuration reads back strength 0, mode 0 and keyed 0. At any time, at most one of idle_o, absorb_o and squeeze_o is high.
- R2: A start command (cmd_i=0) accepted in idle raises absorb_o in the next cycle and drops idle_o.
- R3: A process command (cmd_i=1) accepted in absorb starts a permutation. All three status bits are then low for PERM_LATENCY cycles, and squeeze_o rises after that.
- R4: A run command (cmd_i=2) accepted in squeeze starts one more permutation. The status goes dark for PERM_LATENCY cycles, and squeeze_o rises again after that.
- R5: A done command (cmd_i=3) accepted in squeeze returns the block to idle in the next cycle. In the same cycle, rate_words_o and op_kind_o go back to 0.
- R6: A configuration write (cfg_we_i) made while idle_o is high shows on the readback outputs in the next cycle. A write made in any other phase leaves the readback unchanged.
- R7: A configuration write is dropped as a whole if its strength code is above 4 or its mode code is 3.
- R8: The strength codes 0, 1, 2, 3 and 4 stand for 128, 224, 256, 384 and 512 bits. At start, rate_words_o takes the value (1600 - 2*bits)/32, which gives 42, 36, 34, 26 or 18. The value is held until done.
- R9: At start, op_kind_o takes the following value: mode 0 (fixed hash) gives 0, and mode 1 (extendable output) gives 1. Mode 2 (customisable) gives 2, or 3 if the keyed bit is set. The keyed bit has no effect in modes 0 and 1.
- R10: A command that the current phase does not accept sets err_o, which then stays high until reset. Such a command does not change the phase. This includes any command sent while a permutation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_strength_i | input | 3 | Strength code to write |
| cfg_mode_i | input | 2 | Function family to write |
| cfg_keyed_i | input | 1 | Keyed enable to write |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command code: 0 start, 1 process, 2 run, 3 done |
| cfg_strength_o | output | 3 | Stored strength code |
| cfg_mode_o | output | 2 | Stored function family |
| cfg_keyed_o | output | 1 | Stored keyed enable |
| idle_o | output | 1 | Idle status |
| absorb_o | output | 1 | Absorb status |
| squeeze_o | output | 1 | Squeeze status |
| err_o | output | 1 | Sticky illegal-command flag |
| rate_words_o | output | 6 | Latched rate in 32-bit words |
| op_kind_o | output | 2 | Latched function kind |

## Verification
Every output of this block comes straight from a register. A wrong phase therefore shows on the status bits one cycle after the edge that caused it. Examples are a missed transition, a permutation window that is too short, or an illegal command that is obeyed. A wrong latched rate, a wrong kind or a broken configuration lock shows on the data outputs at the same edge. The bench replays each command against a behavioural model and compares every output on every cycle. The fault is therefore reported within one cycle of its first visible effect.

// File: rtl/sponge_seq_pkg.sv
package sponge_seq_pkg;

    localparam int STATE_BITS = 1600;
    localparam int WORD_W     = 32;
    localparam int MIN_STR    = 128;
    localparam int STR_W      = 3;
    localparam int MODE_W     = 2;
    localparam int KIND_W     = 2;
    localparam int RATE_W     = $clog2((STATE_BITS - 2 * MIN_STR) / WORD_W + 1);

    typedef enum logic [1:0] {
        CMD_START   = 2'd0,
        CMD_PROCESS = 2'd1,
        CMD_RUN     = 2'd2,
        CMD_DONE    = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ABSORB  = 2'd1,
        PH_PERM    = 2'd2,
        PH_SQUEEZE = 2'd3
    } phase_e;

    typedef struct packed {
        logic [STR_W-1:0]  strength;
        logic [MODE_W-1:0] mode;
        logic              keyed;
    } cfg_t;

    function automatic logic cfg_legal(cfg_t c);
        return (c.strength <= STR_W'(4)) && (c.mode != MODE_W'(3));
    endfunction

    function automatic int unsigned strength_bits(logic [STR_W-1:0] s);
        case (s)
            3'd0:    return 128;
            3'd1:    return 224;
            3'd2:    return 256;
            3'd3:    return 384;
            default: return 512;
        endcase
    endfunction

    function automatic logic [RATE_W-1:0] rate_words(logic [STR_W-1:0] s);
        int unsigned r;
        r = (STATE_BITS - 2 * strength_bits(s)) / WORD_W;
        return RATE_W'(r);
    endfunction

    function automatic logic [KIND_W-1:0] op_kind(cfg_t c);
        case (c.mode)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return c.keyed ? 2'd3 : 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/sponge_cfg_reg.sv
module sponge_cfg_reg
    import sponge_seq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic unlock_i,
    input  logic we_i,
    input  cfg_t cfg_i,
    output cfg_t cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i && unlock_i && cfg_legal(cfg_i)) begin
            cfg_d = cfg_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R6: locked outside idle
    p_cfg_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !unlock_i |=> $stable(cfg_q));

    // R7: no illegal encoding is ever stored
    p_cfg_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i && !cfg_legal(cfg_i) |=> $stable(cfg_q));

endmodule

// File: rtl/sponge_perm_stub.sv
module sponge_perm_stub #(
    parameter int LATENCY = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic ack_o
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (req_i) begin
            cnt_d = CNT_W'(LATENCY);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ack_o = (cnt_q == CNT_W'(1));

    // R3 / R4: a new request never overlaps one in flight
    p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0) |-> !req_i);

endmodule

// File: rtl/sponge_seq_fsm.sv
module sponge_seq_fsm
    import sponge_seq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_i,
    input  cfg_t              cfg_i,
    input  logic              perm_ack_i,
    output logic              perm_req_o,
    output logic              idle_o,
    output logic              absorb_o,
    output logic              squeeze_o,
    output logic              err_o,
    output logic [RATE_W-1:0] rate_o,
    output logic [KIND_W-1:0] kind_o
);

    typedef struct packed {
        phase_e              phase;
        logic                err;
        logic [RATE_W-1:0]   rate;
        logic [KIND_W-1:0]   kind;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    cmd_e      cmd;
    logic      start_acc, done_acc;

    assign cmd = cmd_e'(cmd_i);

    always_comb begin
        s_d        = s_q;
        perm_req_o = 1'b0;
        start_acc  = 1'b0;
        done_acc   = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (cmd_valid_i) begin
                    if (cmd == CMD_START) begin
                        start_acc = 1'b1;
                        s_d.phase = PH_ABSORB;
                        s_d.rate  = rate_words(cfg_i.strength);
                        s_d.kind  = op_kind(cfg_i);
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            PH_ABSORB: begin
                if (cmd_valid_i) begin
                    if (cmd == CMD_PROCESS) begin
                        perm_req_o = 1'b1;
                        s_d.phase  = PH_PERM;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            PH_SQUEEZE: begin
                if (cmd_valid_i) begin
                    if (cmd == CMD_RUN) begin
                        perm_req_o = 1'b1;
                        s_d.phase  = PH_PERM;
                    end else if (cmd == CMD_DONE) begin
                        done_acc  = 1'b1;
                        s_d.phase = PH_IDLE;
                        s_d.rate  = '0;
                        s_d.kind  = '0;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            default: begin
                if (cmd_valid_i) begin
                    s_d.err = 1'b1;
                end
                if (perm_ack_i) begin
                    s_d.phase = PH_SQUEEZE;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{phase: PH_IDLE, err: 1'b0, rate: '0, kind: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign idle_o    = (s_q.phase == PH_IDLE);
    assign absorb_o  = (s_q.phase == PH_ABSORB);
    assign squeeze_o = (s_q.phase == PH_SQUEEZE);
    assign err_o     = s_q.err;
    assign rate_o    = s_q.rate;
    assign kind_o    = s_q.kind;

    p_status_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({idle_o, absorb_o, squeeze_o}));

    p_start_absorb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_o && cmd_valid_i && cmd_i == 2'd0 |=> absorb_o);

    p_process_dark_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        absorb_o && cmd_valid_i && cmd_i == 2'd1 |=> !idle_o && !absorb_o && !squeeze_o);

    p_run_dark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        squeeze_o && cmd_valid_i && cmd_i == 2'd2 |=> !idle_o && !absorb_o && !squeeze_o);

    p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        squeeze_o && cmd_valid_i && cmd_i == 2'd3 |=> idle_o && rate_o == '0);

    p_rate_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_acc && !done_acc |=> $stable(rate_o) && $stable(kind_o));

    p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    p_illegal_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        absorb_o && cmd_valid_i && cmd_i != 2'd1 |=> absorb_o && err_o);

endmodule

// File: rtl/sponge_cmd_seq.sv
module sponge_cmd_seq
    import sponge_seq_pkg::*;
#(
    parameter int PERM_LATENCY = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [STR_W-1:0]  cfg_strength_i,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic              cfg_keyed_i,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_i,
    output logic [STR_W-1:0]  cfg_strength_o,
    output logic [MODE_W-1:0] cfg_mode_o,
    output logic              cfg_keyed_o,
    output logic              idle_o,
    output logic              absorb_o,
    output logic              squeeze_o,
    output logic              err_o,
    output logic [RATE_W-1:0] rate_words_o,
    output logic [KIND_W-1:0] op_kind_o
);

    cfg_t cfg_wr, cfg_cur;
    logic perm_req, perm_ack;

    assign cfg_wr = '{strength: cfg_strength_i, mode: cfg_mode_i, keyed: cfg_keyed_i};

    sponge_cfg_reg u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .unlock_i (idle_o),
        .we_i     (cfg_we_i),
        .cfg_i    (cfg_wr),
        .cfg_o    (cfg_cur)
    );

    sponge_seq_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (cmd_i),
        .cfg_i       (cfg_cur),
        .perm_ack_i  (perm_ack),
        .perm_req_o  (perm_req),
        .idle_o      (idle_o),
        .absorb_o    (absorb_o),
        .squeeze_o   (squeeze_o),
        .err_o       (err_o),
        .rate_o      (rate_words_o),
        .kind_o      (op_kind_o)
    );

    sponge_perm_stub #(.LATENCY(PERM_LATENCY)) u_perm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (perm_req),
        .ack_o  (perm_ack)
    );

    assign cfg_strength_o = cfg_cur.strength;
    assign cfg_mode_o     = cfg_cur.mode;
    assign cfg_keyed_o    = cfg_cur.keyed;

endmodule

// File: tb/sponge_cmd_seq_tb_top.sv
module sponge_cmd_seq_tb_top;

    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_str = '0;
    logic [1:0] cfg_mode = '0;
    logic       cfg_key = 1'b0;
    logic       cmd_v = 1'b0;
    logic [1:0] cmd = '0;
    logic [2:0] o_str;
    logic [1:0] o_mode;
    logic       o_key, o_idle, o_abs, o_sqz, o_err;
    logic [5:0] o_rate;
    logic [1:0] o_kind;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    sponge_cmd_seq #(.PERM_LATENCY(LAT)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_strength_i(cfg_str), .cfg_mode_i(cfg_mode), .cfg_keyed_i(cfg_key),
        .cmd_valid_i(cmd_v), .cmd_i(cmd),
        .cfg_strength_o(o_str), .cfg_mode_o(o_mode), .cfg_keyed_o(o_key),
        .idle_o(o_idle), .absorb_o(o_abs), .squeeze_o(o_sqz), .err_o(o_err),
        .rate_words_o(o_rate), .op_kind_o(o_kind)
    );

    // reference model: phase 0 idle, 1 absorb, 2 squeeze, 3 permuting
    int m_ph = 0, m_cnt = 0, m_rate = 0, m_kind = 0, m_str = 0, m_mode = 0;
    bit m_err = 0, m_key = 0;

    function automatic int exp_rate(int s);
        int bits[5] = '{128, 224, 256, 384, 512};
        return (1600 - 2 * bits[s]) / 32;
    endfunction

    function automatic int exp_kind(int mode, bit key);
        if (mode == 2) return key ? 3 : 2;
        return mode;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_cnt <= 0; m_rate <= 0; m_kind <= 0;
            m_str <= 0; m_mode <= 0; m_key <= 0; m_err <= 0;
        end else begin
            if (cfg_we && m_ph == 0 && cfg_str <= 4 && cfg_mode != 3) begin
                m_str <= int'(cfg_str); m_mode <= int'(cfg_mode); m_key <= cfg_key;
            end
            if (m_ph == 3) begin
                if (cmd_v) m_err <= 1;
                if (m_cnt == 1) m_ph <= 2;
                m_cnt <= m_cnt - 1;
            end else if (cmd_v) begin
                if (m_ph == 0 && cmd == 0) begin
                    m_ph <= 1; m_rate <= exp_rate(m_str); m_kind <= exp_kind(m_mode, m_key);
                end else if ((m_ph == 1 && cmd == 1) || (m_ph == 2 && cmd == 2)) begin
                    m_ph <= 3; m_cnt <= LAT;
                end else if (m_ph == 2 && cmd == 3) begin
                    m_ph <= 0; m_rate <= 0; m_kind <= 0;
                end else begin
                    m_err <= 1;
                end
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "idle", int'(o_idle), int'(m_ph == 0));
            chk(cur_req, "absorb", int'(o_abs), int'(m_ph == 1));
            chk(cur_req, "squeeze", int'(o_sqz), int'(m_ph == 2));
            chk(cur_req, "err", int'(o_err), int'(m_err));
            chk(cur_req, "rate", int'(o_rate), m_rate);
            chk(cur_req, "kind", int'(o_kind), m_kind);
            chk(cur_req, "cfg", int'({o_str, o_mode, o_key}), (m_str << 3) | (m_mode << 1) | int'(m_key));
        end
    end

    task automatic do_cmd(int c);
        @(negedge clk); cmd_v = 1'b1; cmd = 2'(c);
        @(negedge clk); cmd_v = 1'b0;
    endtask

    task automatic do_cfg(int s, int m, bit k);
        @(negedge clk); cfg_we = 1'b1; cfg_str = 3'(s); cfg_mode = 2'(m); cfg_key = k;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wait_perm(string req);
        chk(req, "dark", int'({o_idle, o_abs, o_sqz}), 0);
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            chk(req, "dark", int'({o_idle, o_abs, o_sqz}), 0);
        end
        @(negedge clk);
        chk(req, "squeeze after permutation", int'(o_sqz), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset status", int'({o_idle, o_abs, o_sqz, o_err}), 8);
        chk("R1", "reset rate", int'(o_rate), 0);
        chk("R1", "reset kind", int'(o_kind), 0);
        chk("R1", "reset cfg", int'({o_str, o_mode, o_key}), 0);

        cur_req = "R6";
        do_cfg(4, 0, 1'b1);
        chk("R6", "cfg written in idle", int'({o_str, o_mode, o_key}), 6'b100001);

        cur_req = "R2";
        do_cmd(0);
        chk("R2", "absorb after start", int'({o_idle, o_abs}), 1);
        chk("R8", "rate for 512", int'(o_rate), 18);
        chk("R9", "keyed ignored for fixed hash", int'(o_kind), 0);

        cur_req = "R6";
        do_cfg(1, 2, 1'b0);
        chk("R6", "cfg locked in absorb", int'({o_str, o_mode, o_key}), 6'b100001);

        cur_req = "R10";
        chk("R10", "err clear before illegal", int'(o_err), 0);
        do_cmd(0);
        chk("R10", "illegal start sets err", int'(o_err), 1);
        chk("R10", "phase kept", int'(o_abs), 1);

        cur_req = "R3";
        do_cmd(1);
        wait_perm("R3");

        cur_req = "R4";
        do_cmd(2);
        wait_perm("R4");

        cur_req = "R10";
        do_cmd(2);
        do_cmd(3);
        repeat (LAT) @(negedge clk);
        chk("R10", "command during permutation dropped", int'(o_sqz), 1);
        chk("R10", "err stays set", int'(o_err), 1);

        cur_req = "R5";
        do_cmd(3);
        chk("R5", "idle after done", int'(o_idle), 1);
        chk("R5", "rate cleared", int'(o_rate), 0);

        cur_req = "R7";
        do_cfg(5, 1, 1'b0);
        chk("R7", "strength 5 dropped", int'(o_str), 4);
        do_cfg(2, 3, 1'b0);
        chk("R7", "mode 3 dropped", int'({o_str, o_mode}), 5'b10000);

        cur_req = "R8";
        for (int s = 0; s < 5; s++) begin
            do_cfg(s, 2, 1'b1);
            do_cmd(0);
            chk("R8", "rate words", int'(o_rate), (1600 - 2 * (s == 0 ? 128 : s == 1 ? 224 : s == 2 ? 256 : s == 3 ? 384 : 512)) / 32);
            chk("R9", "keyed custom kind", int'(o_kind), 3);
            do_cmd(1);
            repeat (LAT) @(negedge clk);
            do_cmd(3);
        end

        cur_req = "R9";
        do_cfg(0, 2, 1'b0);
        do_cmd(0);
        chk("R9", "custom kind", int'(o_kind), 2);
        do_cmd(1);
        repeat (LAT) @(negedge clk);
        do_cmd(3);
        do_cfg(1, 1, 1'b1);
        do_cmd(0);
        chk("R9", "keyed ignored for xof", int'(o_kind), 1);
        chk("R8", "rate 224", int'(o_rate), 36);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule